// File: doc/BRIEF.md
# Command-Mode Panel Bus Interface

This block runs single register and command accesses to a display panel over an 8080-style parallel bus. The bus has an active-low chip select per panel, a register-select line, separate active-low write and read strobes, and a data bus. Software prepares an access word in a holding register. Flag bits in the upper byte of that word mark it as a write and choose between a command (index) cycle and a data cycle. A separate launch register then starts the cycle and picks either the primary or the secondary panel. For reads, software arms a read-request word and uses its own launch register. The captured panel data comes back in the low 16 bits of the read register.

While a bus cycle runs, a busy flag in the status register is high, and no other launch is accepted. The block also carries a small refresh control. A refresh-mode bit chooses between continuous refresh and single-shot refresh. In single-shot mode, a write to a frame-trigger register emits a one-clock start pulse. The status register also records which panel reported the most recent end of frame.

Top module: `lcd_cmd_port`

## Requirements
- R1: After synchronous reset, both chip selects and both strobes are high, the bus driver is off, `frame_kick` is low, the status register reads 0 and the read register reads 0.
- R2: Register map by word address: 0 = access word, 1 = read request/result, 2 = write launch, 3 = read launch, 4 = status, 5 = mode, 6 = refresh mode, 7 = frame trigger. A write to address 2 with bit 0 set, while the stored access word has bit 28 set, runs one write cycle. During that cycle the chip select of the chosen panel is low (launch bit 1 set = secondary panel). `pnl_rs` equals access-word bit 24 (1 = data cycle, 0 = index cycle), and `pnl_dout` carries access-word bits 15:0 with `pnl_doe` high.
- R3: Every cycle has three phases. First comes one setup clock, with chip select low and both strobes high. Then the strobe is low for exactly STROBE_CLKS clocks. Last comes one hold clock, with the strobe high and chip select still low.
- R4: Status bit 1 (busy) is set from the clock edge that accepts a launch. It stays set until one clock after the strobe rises, so it is high for STROBE_CLKS+2 clocks.
- R5: No bus cycle starts in any of these cases: a launch written while busy, a launch write with bit 0 clear, or a write launch while access-word bit 28 is clear.
- R6: If the read-request register was last written with bit 24 set, a write to address 3 with bit 0 set runs a read cycle. In that cycle `pnl_rd_n` pulses, `pnl_rs` is high and `pnl_doe` is low. The data bus is sampled on the edge where `pnl_rd_n` rises, and address 1 then reads it in bits 15:0 with the upper bits zero. A read launch is ignored when bit 24 was clear.
- R7: Mode bit 12 set selects system-bus mode. A launch for the secondary panel is ignored unless this bit is set. The primary panel is accessible in either mode.
- R8: Mode bits 3:0 give the bus format. Codes 0 to 3 select a narrow bus: only the low half of `pnl_dout` carries data and the upper half is zero. Other codes drive the full width.
- R9: When refresh-mode bit 0 is 1, writing bit 0 set to address 7 raises `frame_kick` for exactly one clock, after the write edge. When the refresh mode is 0, `refresh_cont` is high and `frame_kick` stays low.
- R10: Status bit 10 holds the source of the latest end-of-frame pulse: 1 for `fe_sub` and 0 for `fe_main`. If both pulses arrive in the same clock, the bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pnl_cs_main_n | output | 1 | Primary panel chip select, active low |
| pnl_cs_sub_n | output | 1 | Secondary panel chip select, active low |
| pnl_rs | output | 1 | Register select (1 = data) |
| pnl_wr_n | output | 1 | Write strobe, active low |
| pnl_rd_n | output | 1 | Read strobe, active low |
| pnl_dout | output | 16 | Data driven to the panel |
| pnl_doe | output | 1 | Data output enable |
| pnl_din | input | 16 | Data from the panel |
| fe_main | input | 1 | End-of-frame pulse, primary panel |
| fe_sub | input | 1 | End-of-frame pulse, secondary panel |
| frame_kick | output | 1 | Single-shot frame start pulse |
| refresh_cont | output | 1 | High in continuous refresh mode |

## Verification
Write cycles are issued with several access words: an index write to the primary panel, a data write to the secondary panel, and a narrow-format write with a full 16-bit pattern. Comparing these shows whether register select, chip-select routing and the upper-byte masking each follow their own control bit. Launches that must be refused are mixed in with accepted ones: a cleared launch bit, a word with no write flag, a back-to-back launch, and a secondary-panel launch in parallel mode. Any refused launch that still produces a strobe shows up as an unmatched bus cycle. A read is checked with the input bus changed after capture, which separates sampling on the strobe's rising edge from tracking the input.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    localparam int REG_ADDR_W    = 3;
    localparam int FMT_W         = 4;
    localparam int CMD_WRITE_BIT = 28;
    localparam int CMD_DATA_BIT  = 24;
    localparam int RDREQ_BIT     = 24;
    localparam int GO_LAUNCH_BIT = 0;
    localparam int GO_SUB_BIT    = 1;
    localparam int STAT_BUSY_BIT = 1;
    localparam int STAT_SRC_BIT  = 10;
    localparam int MODE_SYS_BIT  = 12;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_CMD    = 3'd0,
        RA_RDREQ  = 3'd1,
        RA_WGO    = 3'd2,
        RA_RGO    = 3'd3,
        RA_STAT   = 3'd4,
        RA_MODE   = 3'd5,
        RA_RFMODE = 3'd6,
        RA_FGO    = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        OP_INDEX = 2'd0,
        OP_DATA  = 2'd1,
        OP_READ  = 2'd2
    } bus_op_e;

    typedef struct packed {
        bus_op_e op;
        logic    sub;
    } bus_req_t;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_SETUP,
        BS_STROBE,
        BS_HOLD
    } bus_state_e;

    function automatic logic fmt_is_narrow(input logic [FMT_W-1:0] fmt);
        return fmt < 4'd4;
    endfunction

endpackage

// File: rtl/lcd_cmd_regs.sv
module lcd_cmd_regs
    import lcd_cmd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic                  busy,
    input  logic [DATA_W-1:0]     rd_capture,
    input  logic                  src_sub,
    output logic                  launch,
    output bus_req_t              req,
    output logic [DATA_W-1:0]     req_data,
    output logic                  mode_sys,
    output logic                  refresh_single,
    output logic                  frame_go_wr
);

    localparam int NARROW_W = DATA_W / 2;

    reg_addr_e          addr;
    logic [REG_W-1:0]   cmd_q;
    logic               rdreq_q;
    logic               mode_sys_q;
    logic [FMT_W-1:0]   fmt_q;
    logic               rfmode_q;
    logic               go_w, go_r, go_sub, panel_ok;

    assign addr = reg_addr_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            rdreq_q    <= 1'b0;
            mode_sys_q <= 1'b0;
            fmt_q      <= '0;
            rfmode_q   <= 1'b0;
        end else if (reg_we) begin
            case (addr)
                RA_CMD:    cmd_q    <= reg_wdata;
                RA_RDREQ:  rdreq_q  <= reg_wdata[RDREQ_BIT];
                RA_MODE: begin
                    mode_sys_q <= reg_wdata[MODE_SYS_BIT];
                    fmt_q      <= reg_wdata[FMT_W-1:0];
                end
                RA_RFMODE: rfmode_q <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // launch decode: one launch per accepted write to a go register
    assign go_w     = reg_we && (addr == RA_WGO) && reg_wdata[GO_LAUNCH_BIT];
    assign go_r     = reg_we && (addr == RA_RGO) && reg_wdata[GO_LAUNCH_BIT];
    assign go_sub   = reg_wdata[GO_SUB_BIT];
    assign panel_ok = !busy && (!go_sub || mode_sys_q);
    assign launch   = panel_ok && ((go_w && cmd_q[CMD_WRITE_BIT]) || (go_r && rdreq_q));

    assign req.sub = go_sub;
    assign req.op  = go_r ? OP_READ : (cmd_q[CMD_DATA_BIT] ? OP_DATA : OP_INDEX);

    generate
        if (NARROW_W > 0) begin : g_fmt_mask
            assign req_data = fmt_is_narrow(fmt_q)
                ? {{(DATA_W-NARROW_W){1'b0}}, cmd_q[NARROW_W-1:0]}
                : cmd_q[DATA_W-1:0];
        end else begin : g_fmt_pass
            assign req_data = cmd_q[DATA_W-1:0];
        end
    endgenerate

    assign mode_sys       = mode_sys_q;
    assign refresh_single = rfmode_q;
    assign frame_go_wr    = reg_we && (addr == RA_FGO) && reg_wdata[0];

    always_comb begin
        reg_rdata = '0;
        case (addr)
            RA_CMD:    reg_rdata = cmd_q;
            RA_RDREQ:  reg_rdata = REG_W'(rd_capture);
            RA_STAT: begin
                reg_rdata[STAT_BUSY_BIT] = busy;
                reg_rdata[STAT_SRC_BIT]  = src_sub;
            end
            RA_MODE: begin
                reg_rdata[MODE_SYS_BIT] = mode_sys_q;
                reg_rdata[FMT_W-1:0]    = fmt_q;
            end
            RA_RFMODE: reg_rdata[0] = rfmode_q;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lcd_bus_seq.sv
module lcd_bus_seq
    import lcd_cmd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int STROBE_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] pnl_din,
    output logic              busy,
    output logic              cs_main_n,
    output logic              cs_sub_n,
    output logic              rs,
    output logic              wr_n,
    output logic              rd_n,
    output logic [DATA_W-1:0] dout,
    output logic              doe,
    output logic [DATA_W-1:0] rd_capture
);

    localparam int CNT_W = $clog2(STROBE_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);

    bus_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    bus_req_t          cur_q;
    logic [DATA_W-1:0] data_q;
    logic              active, strobing, is_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= BS_IDLE;
            cnt_q      <= '0;
            cur_q      <= '{op: OP_INDEX, sub: 1'b0};
            data_q     <= '0;
            rd_capture <= '0;
        end else begin
            case (state_q)
                BS_IDLE: if (launch) begin
                    state_q <= BS_SETUP;
                    cur_q   <= req;
                    data_q  <= req_data;
                    cnt_q   <= '0;
                end
                BS_SETUP: begin
                    state_q <= BS_STROBE;
                    cnt_q   <= '0;
                end
                BS_STROBE: begin
                    if (cnt_q == CNT_LAST) begin
                        state_q <= BS_HOLD;
                        if (cur_q.op == OP_READ) rd_capture <= pnl_din;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= BS_IDLE;
            endcase
        end
    end

    assign active    = (state_q != BS_IDLE);
    assign strobing  = (state_q == BS_STROBE);
    assign is_read   = (cur_q.op == OP_READ);
    assign busy      = active;
    assign cs_main_n = !(active && !cur_q.sub);
    assign cs_sub_n  = !(active && cur_q.sub);
    assign rs        = active && (cur_q.op != OP_INDEX);
    assign wr_n      = !(strobing && !is_read);
    assign rd_n      = !(strobing && is_read);
    assign doe       = active && !is_read;
    assign dout      = doe ? data_q : '0;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!wr_n && !rd_n));                                           // R3
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!cs_main_n, !cs_sub_n}));                           // R2
    AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!wr_n || !rd_n) |-> (busy && !(cs_main_n && cs_sub_n)));     // R4
    AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && ($past(wr_n) == 1'b0)) |-> $stable(dout));          // R2
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (!doe && rs));                                      // R6
    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> busy);                                        // R4

endmodule

// File: rtl/lcd_frame_ctl.sv
module lcd_frame_ctl (
    input  logic clk,
    input  logic rst,
    input  logic refresh_single,
    input  logic frame_go_wr,
    input  logic fe_main,
    input  logic fe_sub,
    output logic frame_kick,
    output logic refresh_cont,
    output logic src_sub
);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_kick <= 1'b0;
            src_sub    <= 1'b0;
        end else begin
            frame_kick <= frame_go_wr && refresh_single;
            if (fe_sub)       src_sub <= 1'b1;
            else if (fe_main) src_sub <= 1'b0;
        end
    end

    assign refresh_cont = !refresh_single;

    AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_kick |-> !refresh_cont);                                // R9
    AST_SRC_SUB: assert property (@(posedge clk) disable iff (rst)
        fe_sub |=> src_sub);                                          // R10

endmodule

// File: rtl/lcd_cmd_port.sv
module lcd_cmd_port
    import lcd_cmd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int REG_W       = 32,
    parameter int STROBE_CLKS = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  pnl_cs_main_n,
    output logic                  pnl_cs_sub_n,
    output logic                  pnl_rs,
    output logic                  pnl_wr_n,
    output logic                  pnl_rd_n,
    output logic [DATA_W-1:0]     pnl_dout,
    output logic                  pnl_doe,
    input  logic [DATA_W-1:0]     pnl_din,
    input  logic                  fe_main,
    input  logic                  fe_sub,
    output logic                  frame_kick,
    output logic                  refresh_cont
);

    logic              busy, launch, mode_sys, refresh_single, frame_go_wr, src_sub;
    bus_req_t          req;
    logic [DATA_W-1:0] req_data, rd_capture;

    lcd_cmd_regs #(.DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
        .clk            (clk),
        .rst            (rst),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .busy           (busy),
        .rd_capture     (rd_capture),
        .src_sub        (src_sub),
        .launch         (launch),
        .req            (req),
        .req_data       (req_data),
        .mode_sys       (mode_sys),
        .refresh_single (refresh_single),
        .frame_go_wr    (frame_go_wr)
    );

    lcd_bus_seq #(.DATA_W(DATA_W), .STROBE_CLKS(STROBE_CLKS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .req        (req),
        .req_data   (req_data),
        .pnl_din    (pnl_din),
        .busy       (busy),
        .cs_main_n  (pnl_cs_main_n),
        .cs_sub_n   (pnl_cs_sub_n),
        .rs         (pnl_rs),
        .wr_n       (pnl_wr_n),
        .rd_n       (pnl_rd_n),
        .dout       (pnl_dout),
        .doe        (pnl_doe),
        .rd_capture (rd_capture)
    );

    lcd_frame_ctl u_frame (
        .clk            (clk),
        .rst            (rst),
        .refresh_single (refresh_single),
        .frame_go_wr    (frame_go_wr),
        .fe_main        (fe_main),
        .fe_sub         (fe_sub),
        .frame_kick     (frame_kick),
        .refresh_cont   (refresh_cont),
        .src_sub        (src_sub)
    );

    AST_SUB_NEEDS_SYSBUS: assert property (@(posedge clk) disable iff (rst)
        $fell(pnl_cs_sub_n) |-> mode_sys);                            // R7

endmodule

// File: tb/lcd_cmd_port_bench.sv
module lcd_cmd_port_bench;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        pnl_cs_main_n, pnl_cs_sub_n, pnl_rs, pnl_wr_n, pnl_rd_n, pnl_doe;
    logic [15:0] pnl_dout, pnl_din;
    logic        fe_main, fe_sub, frame_kick, refresh_cont;

    always #2 clk = ~clk;

    lcd_cmd_port #(.DATA_W(16), .REG_W(32), .STROBE_CLKS(N)) u_lcd_cmd_port (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pnl_cs_main_n(pnl_cs_main_n), .pnl_cs_sub_n(pnl_cs_sub_n),
        .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
        .pnl_dout(pnl_dout), .pnl_doe(pnl_doe), .pnl_din(pnl_din),
        .fe_main(fe_main), .fe_sub(fe_sub),
        .frame_kick(frame_kick), .refresh_cont(refresh_cont)
    );

    typedef struct {
        logic        sub;
        logic        rs;
        logic        rd;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   vectors = 0;
    int   miscompares = 0;
    int   strobes_seen = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected item per strobe
    initial begin
        logic prev;
        logic s;
        int   width;
        exp_t e;
        prev = 1'b0;
        width = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev = 1'b0;
            end else begin
                s = !pnl_wr_n || !pnl_rd_n;
                if (s && !prev) begin
                    strobes_seen++;
                    width = 1;
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R5 unexpected bus strobe", 32'(pnl_dout), 32'h0);
                    end else begin
                        e = sb_q.pop_front();
                        check(pnl_cs_sub_n == !e.sub && pnl_cs_main_n == e.sub,
                              {e.tag, " R2 chip select"},
                              {30'h0, pnl_cs_sub_n, pnl_cs_main_n}, {30'h0, !e.sub, e.sub});
                        check(pnl_rs == e.rs, {e.tag, " R2 register select"},
                              32'(pnl_rs), 32'(e.rs));
                        check(!pnl_rd_n == e.rd, {e.tag, " R6 strobe kind"},
                              32'(!pnl_rd_n), 32'(e.rd));
                        if (!e.rd)
                            check(pnl_dout == e.data && pnl_doe, {e.tag, " R2 bus data"},
                                  {15'h0, pnl_doe, pnl_dout}, {15'h0, 1'b1, e.data});
                        else
                            check(!pnl_doe, {e.tag, " R6 driver off in read"},
                                  32'(pnl_doe), 32'h0);
                    end
                end else if (s) begin
                    width++;
                end else if (prev) begin
                    check(width == N, "R3 strobe width", 32'(width), 32'(N));
                end
                prev = s;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd4;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic go_and_time(input logic [2:0] a, input logic [31:0] d, input logic sub);
        int  n;
        bit  hold_ok;
        wr(a, d);
        check(reg_rdata[1] == 1'b1, "R4 busy after launch", 32'(reg_rdata[1]), 32'h1);
        check((sub ? (!pnl_cs_sub_n && pnl_cs_main_n) : (!pnl_cs_main_n && pnl_cs_sub_n))
              && pnl_wr_n && pnl_rd_n, "R3 setup cycle",
              {28'h0, pnl_cs_sub_n, pnl_cs_main_n, pnl_wr_n, pnl_rd_n},
              {28'h0, !sub, sub, 1'b1, 1'b1});
        n = 1;
        hold_ok = 1'b0;
        while (n < 50) begin
            hold_ok = pnl_wr_n && pnl_rd_n && !(pnl_cs_main_n && pnl_cs_sub_n);
            @(negedge clk);
            #1;
            if (!reg_rdata[1]) break;
            n++;
        end
        check(n == N + 2, "R4 busy length", 32'(n), 32'(N + 2));
        check(hold_ok, "R3 hold cycle", 32'(hold_ok), 32'h1);
    endtask

    task automatic expect_idle(input string tag);
        bit quiet;
        quiet = 1'b1;
        for (int i = 0; i < N + 4; i++) begin
            @(negedge clk);
            #1;
            if (reg_rdata[1] || !pnl_cs_main_n || !pnl_cs_sub_n) quiet = 1'b0;
        end
        check(quiet, tag, 32'(quiet), 32'h1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit          seen;
        rst = 1'b1; reg_we = 1'b0; reg_addr = 3'd4; reg_wdata = '0;
        pnl_din = '0; fe_main = 1'b0; fe_sub = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(pnl_cs_main_n && pnl_cs_sub_n && pnl_wr_n && pnl_rd_n && !pnl_doe && !frame_kick,
              "R1 idle bus after reset",
              {26'h0, pnl_cs_main_n, pnl_cs_sub_n, pnl_wr_n, pnl_rd_n, pnl_doe, frame_kick},
              32'h3C);
        rd(3'd4, d);
        check(d == 32'h0, "R1 status after reset", d, 32'h0);
        rd(3'd1, d);
        check(d == 32'h0, "R1 read register after reset", d, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        wr(3'd5, 32'h0000_1007);

        // R2 index write to the primary panel
        sb_q.push_back('{sub: 1'b0, rs: 1'b0, rd: 1'b0, data: 16'hABCD, tag: "R2 index write"});
        wr(3'd0, 32'h1000_ABCD);
        go_and_time(3'd2, 32'h1, 1'b0);

        // R2 data write to the secondary panel
        sb_q.push_back('{sub: 1'b1, rs: 1'b1, rd: 1'b0, data: 16'h1234, tag: "R2 data write"});
        wr(3'd0, 32'h1100_1234);
        go_and_time(3'd2, 32'h3, 1'b1);

        // R5 refused launches
        wr(3'd2, 32'h2);
        expect_idle("R5 launch bit clear");
        wr(3'd0, 32'h0100_5555);
        wr(3'd2, 32'h1);
        expect_idle("R5 no write flag");

        // R5 launch while busy
        wr(3'd0, 32'h1100_00F0);
        sb_q.push_back('{sub: 1'b0, rs: 1'b1, rd: 1'b0, data: 16'h00F0, tag: "R5 first launch"});
        wr(3'd2, 32'h1);
        wr(3'd2, 32'h1);
        repeat (N + 6) @(negedge clk);
        check(strobes_seen == 3, "R5 launch while busy", 32'(strobes_seen), 32'd3);

        // R8 narrow bus format
        wr(3'd5, 32'h0000_1002);
        sb_q.push_back('{sub: 1'b0, rs: 1'b1, rd: 1'b0, data: 16'h00EF, tag: "R8 narrow data"});
        wr(3'd0, 32'h1100_BEEF);
        go_and_time(3'd2, 32'h1, 1'b0);
        wr(3'd5, 32'h0000_1007);

        // R6 read cycle
        pnl_din = 16'h5A3C;
        wr(3'd1, 32'h0100_0000);
        sb_q.push_back('{sub: 1'b0, rs: 1'b1, rd: 1'b1, data: 16'h0, tag: "R6 read"});
        go_and_time(3'd3, 32'h1, 1'b0);
        pnl_din = 16'hFFFF;
        rd(3'd1, d);
        check(d == 32'h0000_5A3C, "R6 read capture", d, 32'h0000_5A3C);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'h1);
        expect_idle("R6 read without request flag");

        // R7 secondary panel refused in parallel mode
        wr(3'd5, 32'h0000_0007);
        wr(3'd0, 32'h1100_0077);
        wr(3'd2, 32'h3);
        expect_idle("R7 secondary panel in parallel mode");
        sb_q.push_back('{sub: 1'b0, rs: 1'b1, rd: 1'b0, data: 16'h0077, tag: "R7 primary panel"});
        go_and_time(3'd2, 32'h1, 1'b0);

        // R9 refresh modes
        wr(3'd6, 32'h0);
        check(refresh_cont == 1'b1, "R9 continuous flag", 32'(refresh_cont), 32'h1);
        wr(3'd7, 32'h1);
        seen = frame_kick;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            seen = seen | frame_kick;
        end
        check(!seen, "R9 no kick in continuous mode", 32'(seen), 32'h0);
        wr(3'd6, 32'h1);
        check(refresh_cont == 1'b0, "R9 single-shot flag", 32'(refresh_cont), 32'h0);
        wr(3'd7, 32'h1);
        check(frame_kick == 1'b1, "R9 kick pulse", 32'(frame_kick), 32'h1);
        @(negedge clk);
        #1;
        check(frame_kick == 1'b0, "R9 kick one clock", 32'(frame_kick), 32'h0);

        // R10 end-of-frame source
        @(negedge clk); fe_sub = 1'b1;
        @(negedge clk); fe_sub = 1'b0; #1;
        check(reg_rdata[10] == 1'b1, "R10 source secondary", 32'(reg_rdata[10]), 32'h1);
        @(negedge clk); fe_main = 1'b1;
        @(negedge clk); fe_main = 1'b0; #1;
        check(reg_rdata[10] == 1'b0, "R10 source primary", 32'(reg_rdata[10]), 32'h0);
        @(negedge clk); fe_main = 1'b1; fe_sub = 1'b1;
        @(negedge clk); fe_main = 1'b0; fe_sub = 1'b0; #1;
        check(reg_rdata[10] == 1'b1, "R10 simultaneous pulses", 32'(reg_rdata[10]), 32'h1);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R2 every expected cycle seen", 32'(sb_q.size()), 32'h0);
        summary();
        $finish;
    end

endmodule